// File: doc/BRIEF.md
# Single-Operand ALU with Implicit Temp

This block is the 32-bit arithmetic and logic unit of a processor whose instructions name only one register. The second operand is always a hidden temp register. Each operation takes the nominated register value and the temp value. It returns a result and a write enable, and it updates a Zero flag and a Carry flag that the unit holds itself. Subtract-with-carry, add-with-carry and the rotate-through-carry operations read the held Carry flag.

An operation is presented with `op_valid_i` high for one clock. The result, the write enables and the new flags appear on the outputs one clock after that edge. The parameter `RESULT_TO_TEMP` fixes the destination of results. When it is 0, results raise `wr_reg_o` and go to the nominated register. When it is 1, results raise `wr_tmp_o` and go to temp. Register file, decode and multiplication are outside this block.

Top module: `sop_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o`, `wr_reg_o`, `wr_tmp_o`, `zero_o` and `carry_o` are all 0 after that edge.
- R2: Op 0 (add) yields reg + temp and op 1 (add with carry) yields reg + temp + Carry. For both, the new Carry is the carry out of bit 31.
- R3: Op 2 yields reg - temp, op 3 yields temp - reg, and op 4 yields reg - temp - Carry. For all three, the new Carry is 1 exactly when the true difference is negative (a borrow).
- R4: Op 5 (compare) sets Zero and Carry as op 2 would. It raises no write enable and leaves `result_o` unchanged.
- R5: Op 6 (and), op 7 (or) and op 8 (xor) combine reg with temp bitwise and leave Carry unchanged.
- R6: The shift amount n is temp bits [4:0]. Op 9 shifts reg left by n, op 10 shifts it right by n filling zeros, and op 11 shifts it right by n copying bit 31. Carry is unchanged.
- R7: Op 12 rotates reg left by n = temp[4:0], and Carry is unchanged.
- R8: Op 13 rotates the 33-bit value {Carry, reg} left by n = temp[4:0], and op 14 rotates it right by n. The low 32 bits become the result and bit 32 becomes the new Carry.
- R9: Every accepted operation other than op 15 sets Zero to 1 exactly when its 32-bit result, or for op 5 its difference, is all zeros.
- R10: Results, write enables and flags show one clock after the edge that accepted the operation. After a clock with `op_valid_i` low, no write enable is raised and `result_o`, `zero_o` and `carry_o` hold.
- R11: With `RESULT_TO_TEMP` = 0 a writing operation raises only `wr_reg_o`, and with 1 only `wr_tmp_o`. The two enables are never high together.
- R12: Op 15 is reserved. It raises no write enable and leaves `result_o`, `zero_o` and `carry_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| reg_val_i | input | W (32) | Value of the nominated register |
| tmp_val_i | input | W (32) | Value of the temp register |
| result_o | output | W (32) | Last written result |
| wr_reg_o | output | 1 | Write result to the nominated register |
| wr_tmp_o | output | 1 | Write result to temp |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |

## Verification
Every output of this unit is due exactly one rising edge after the edge that accepts an operation. Flags, result and enables all change together, and nothing is pending longer. The bench drives each operation at a falling edge and lets one rising edge pass. At the following falling edge it compares all five outputs against a behavioural model that was advanced by the same operation. The Carry used by add-with-carry, subtract-with-carry and the carry rotates is therefore the model's value from the previous compare, so chains of carry-consuming operations are checked in order.

// File: rtl/sop_alu_pkg.sv
package sop_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBR = 4'd3,
        OP_SUBC = 4'd4,
        OP_CMP  = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_ASR  = 4'd11,
        OP_ROL  = 4'd12,
        OP_ROLC = 4'd13,
        OP_RORC = 4'd14,
        OP_RSVD = 4'd15
    } op_e;

    typedef struct packed {
        logic zero;
        logic carry;
    } flags_t;

    // arithmetic group: handled by the adder/subtractor
    function automatic logic op_is_arith(op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) ||
               (op == OP_SUBR) || (op == OP_SUBC) || (op == OP_CMP);
    endfunction

    // operations that produce a written result
    function automatic logic op_writes(op_e op);
        return (op != OP_CMP) && (op != OP_RSVD);
    endfunction

    // operations that update the Carry flag
    function automatic logic op_sets_carry(op_e op);
        return op_is_arith(op) || (op == OP_ROLC) || (op == OP_RORC);
    endfunction

endpackage

// File: rtl/sop_alu_arith.sv
module sop_alu_arith
    import sop_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] nom,
    input  logic [W-1:0] tmp,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int EW = W + 1;

    logic [EW-1:0] a_x, b_x, c_x, full;

    always_comb begin
        a_x = {1'b0, nom};
        b_x = {1'b0, tmp};
        c_x = {{W{1'b0}}, cin};
        case (op)
            OP_ADD:         full = a_x + b_x;
            OP_ADDC:        full = a_x + b_x + c_x;
            OP_SUB, OP_CMP: full = a_x - b_x;
            OP_SUBR:        full = b_x - a_x;
            OP_SUBC:        full = a_x - b_x - c_x;
            default:        full = '0;
        endcase
        // top bit is carry out for adds, borrow (negative) for subtracts
        res  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/sop_alu_bitops.sv
module sop_alu_bitops
    import sop_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] nom,
    input  logic [W-1:0] tmp,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    localparam int SHW = $clog2(W);
    localparam int AW  = SHW + 1;

    logic [SHW-1:0] amt;
    logic [AW-1:0]  amt_x, back_w, back_r;
    logic [W:0]     ring, ring_l, ring_r;
    logic [W-1:0]   rot_l;

    always_comb begin
        amt    = tmp[SHW-1:0];
        amt_x  = {1'b0, amt};
        back_w = AW'(W) - amt_x;
        back_r = AW'(W + 1) - amt_x;
        ring   = {cin, nom};
        rot_l  = (nom << amt) | (nom >> back_w);
        ring_l = (ring << amt) | (ring >> back_r);
        ring_r = (ring >> amt) | (ring << back_r);

        cout = cin;
        case (op)
            OP_AND:  res = nom & tmp;
            OP_OR:   res = nom | tmp;
            OP_XOR:  res = nom ^ tmp;
            OP_SHL:  res = nom << amt;
            OP_SHR:  res = nom >> amt;
            OP_ASR:  res = W'($signed(nom) >>> amt);
            OP_ROL:  res = rot_l;
            OP_ROLC: begin
                res  = ring_l[W-1:0];
                cout = ring_l[W];
            end
            OP_RORC: begin
                res  = ring_r[W-1:0];
                cout = ring_r[W];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/sop_alu_wb.sv
module sop_alu_wb #(
    parameter bit TO_TEMP = 1'b0
) (
    input  logic wr,
    output logic wr_reg,
    output logic wr_tmp
);
    generate
        if (TO_TEMP) begin : g_to_temp
            assign wr_tmp = wr;
            assign wr_reg = 1'b0;
        end else begin : g_to_reg
            assign wr_reg = wr;
            assign wr_tmp = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_alu_pkg::*;
#(
    parameter int W              = 32,
    parameter bit RESULT_TO_TEMP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] reg_val_i,
    input  logic [W-1:0] tmp_val_i,
    output logic [W-1:0] result_o,
    output logic         wr_reg_o,
    output logic         wr_tmp_o,
    output logic         zero_o,
    output logic         carry_o
);
    op_e          op;
    flags_t       flg_q;
    logic [W-1:0] res_q, ar_res, bo_res, res_nx;
    logic         wr_q, ar_c, bo_c, c_nx, take;

    assign op = op_e'(op_i);

    sop_alu_arith #(.W(W)) u_arith (
        .op(op), .nom(reg_val_i), .tmp(tmp_val_i), .cin(flg_q.carry),
        .res(ar_res), .cout(ar_c)
    );

    sop_alu_bitops #(.W(W)) u_bitops (
        .op(op), .nom(reg_val_i), .tmp(tmp_val_i), .cin(flg_q.carry),
        .res(bo_res), .cout(bo_c)
    );

    always_comb begin
        res_nx = op_is_arith(op) ? ar_res : bo_res;
        c_nx   = op_is_arith(op) ? ar_c   : bo_c;
        take   = op_valid_i && (op != OP_RSVD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            flg_q <= '0;
        end else begin
            wr_q <= take && op_writes(op);
            if (take && op_writes(op)) begin
                res_q <= res_nx;
            end
            if (take) begin
                flg_q.zero <= (res_nx == '0);
                if (op_sets_carry(op)) begin
                    flg_q.carry <= c_nx;
                end
            end
        end
    end

    sop_alu_wb #(.TO_TEMP(RESULT_TO_TEMP)) u_wb (
        .wr(wr_q), .wr_reg(wr_reg_o), .wr_tmp(wr_tmp_o)
    );

    assign result_o = res_q;
    assign zero_o   = flg_q.zero;
    assign carry_o  = flg_q.carry;
endmodule

// File: rtl/sop_alu_chk.sv
module sop_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] reg_val_i,
    input logic [W-1:0] tmp_val_i,
    input logic [W-1:0] result_o,
    input logic         wr_reg_o,
    input logic         wr_tmp_o,
    input logic         zero_o,
    input logic         carry_o
);
    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && op_i == 4'd0 |=> result_o == $past(reg_val_i + tmp_val_i)); // R2

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && op_i == 4'd5 |=> !wr_reg_o && !wr_tmp_o && $stable(result_o)); // R4

    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && op_i >= 4'd6 && op_i <= 4'd12 |=> $stable(carry_o)); // R5

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && op_i != 4'd5 && op_i != 4'd15 |=> zero_o == (result_o == '0)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> !wr_reg_o && !wr_tmp_o && $stable(result_o)
                        && $stable(zero_o) && $stable(carry_o)); // R10

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
        !(wr_reg_o && wr_tmp_o)); // R11

    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        op_valid_i && op_i == 4'd15 |=> !wr_reg_o && !wr_tmp_o
                        && $stable(zero_o) && $stable(carry_o)); // R12
endmodule

bind sop_alu sop_alu_chk #(.W(W)) u_sop_alu_chk (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
    .reg_val_i(reg_val_i), .tmp_val_i(tmp_val_i), .result_o(result_o),
    .wr_reg_o(wr_reg_o), .wr_tmp_o(wr_tmp_o), .zero_o(zero_o),
    .carry_o(carry_o)
);

// File: tb/test_sop_alu.sv
module test_sop_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] reg_val_i = '0;
    logic [31:0] tmp_val_i = '0;
    logic [31:0] result_o;
    logic        wr_reg_o, wr_tmp_o, zero_o, carry_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic [31:0] m_res = '0;
    logic        m_wr  = 1'b0;
    logic        m_z   = 1'b0;
    logic        m_c   = 1'b0;

    sop_alu i_sop_alu (
        .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_i(op_i),
        .reg_val_i(reg_val_i), .tmp_val_i(tmp_val_i), .result_o(result_o),
        .wr_reg_o(wr_reg_o), .wr_tmp_o(wr_tmp_o), .zero_o(zero_o),
        .carry_o(carry_o)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [3:0] op);
        if (!v) return "R10";
        case (op)
            4'd0, 4'd1:         return "R2";
            4'd2, 4'd3, 4'd4:   return "R3";
            4'd5:               return "R4";
            4'd6, 4'd7, 4'd8:   return "R5";
            4'd9, 4'd10, 4'd11: return "R6";
            4'd12:              return "R7";
            4'd13, 4'd14:       return "R8";
            default:            return "R12";
        endcase
    endfunction

    // present one operation at a falling edge, compare after one rising edge
    task automatic apply(input logic v, input logic [3:0] op,
                         input logic [31:0] r, input logic [31:0] t);
        logic [32:0] wide;
        logic [31:0] x;
        logic        nc, wr, upd;
        int          n;
        string       tg;
        op_valid_i = v;
        op_i       = op;
        reg_val_i  = r;
        tmp_val_i  = t;
        n   = int'(t[4:0]);
        x   = m_res;
        nc  = m_c;
        wr  = 1'b0;
        upd = 1'b0;
        if (v && op != 4'd15) begin
            upd = 1'b1;
            wr  = (op != 4'd5);
            case (op)
                4'd0: begin wide = 33'(r) + 33'(t);         x = wide[31:0]; nc = wide[32]; end
                4'd1: begin wide = 33'(r) + 33'(t) + 33'(m_c); x = wide[31:0]; nc = wide[32]; end
                4'd2, 4'd5: begin x = r - t; nc = (r < t); end
                4'd3: begin x = t - r; nc = (t < r); end
                4'd4: begin x = r - t - 32'(m_c); nc = (33'(r) < 33'(t) + 33'(m_c)); end
                4'd6: x = r & t;
                4'd7: x = r | t;
                4'd8: x = r ^ t;
                4'd9: begin x = r; for (int k = 0; k < n; k++) x = {x[30:0], 1'b0}; end
                4'd10: begin x = r; for (int k = 0; k < n; k++) x = {1'b0, x[31:1]}; end
                4'd11: begin x = r; for (int k = 0; k < n; k++) x = {x[31], x[31:1]}; end
                4'd12: begin x = r; for (int k = 0; k < n; k++) x = {x[30:0], x[31]}; end
                4'd13: begin
                    x = r;
                    for (int k = 0; k < n; k++) begin
                        logic top;
                        top = x[31];
                        x = {x[30:0], nc};
                        nc = top;
                    end
                end
                default: begin
                    x = r;
                    for (int k = 0; k < n; k++) begin
                        logic bot;
                        bot = x[0];
                        x = {nc, x[31:1]};
                        nc = bot;
                    end
                end
            endcase
        end
        tg = tag_of(v, op);
        @(posedge clk);
        @(negedge clk);
        m_wr = wr;
        if (upd) begin
            m_z = (x == 32'd0);
            m_c = nc;
            if (wr) m_res = x;
        end
        check({tg, " result"}, result_o, m_res);
        check({tg, " wr_reg"}, 32'(wr_reg_o), 32'(m_wr));
        check("R11 wr_tmp", 32'(wr_tmp_o), 32'd0);
        check({tg, " R9 zero"}, 32'(zero_o), 32'(m_z));
        check({tg, " carry"}, 32'(carry_o), 32'(m_c));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 result", result_o, 32'd0);
        check("R1 wr_reg", 32'(wr_reg_o), 32'd0);
        check("R1 wr_tmp", 32'(wr_tmp_o), 32'd0);
        check("R1 zero", 32'(zero_o), 32'd0);
        check("R1 carry", 32'(carry_o), 32'd0);
        rst = 1'b0;

        apply(1'b1, 4'd0, 32'hFFFF_FFFF, 32'd1);        // R2 wrap: 0, Z=1 C=1
        apply(1'b1, 4'd1, 32'd5, 32'd6);                // R2 add carry: 12
        apply(1'b1, 4'd2, 32'd5, 32'd7);                // R3 borrow
        apply(1'b1, 4'd4, 32'd10, 32'd3);               // R3 10-3-1 = 6
        apply(1'b1, 4'd3, 32'd2, 32'd9);                // R3 reverse: 7
        apply(1'b1, 4'd5, 32'd7, 32'd7);                // R4 equal, no write
        apply(1'b1, 4'd5, 32'd1, 32'd2);                // R4 borrow
        apply(1'b1, 4'd6, 32'h0000_F0F0, 32'h0000_0FF0); // R5
        apply(1'b1, 4'd7, 32'h0000_F0F0, 32'h0F00_0000); // R5
        apply(1'b1, 4'd8, 32'hA5A5_A5A5, 32'hA5A5_A5A5); // R5 zero
        apply(1'b1, 4'd9, 32'h8000_0001, 32'h0000_0021); // R6 n=1
        apply(1'b1, 4'd11, 32'h8000_0000, 32'd31);       // R6 sign fill
        apply(1'b1, 4'd10, 32'h8000_0000, 32'd31);       // R6 zero fill
        apply(1'b1, 4'd12, 32'h8000_0001, 32'd4);        // R7
        apply(1'b1, 4'd12, 32'h1234_5678, 32'd0);        // R7 n=0
        apply(1'b1, 4'd2, 32'd0, 32'd1);                 // C=1
        apply(1'b1, 4'd13, 32'd0, 32'd1);                // R8 carry in
        apply(1'b1, 4'd14, 32'd1, 32'd1);                // R8 carry out, Z=1
        apply(1'b1, 4'd13, 32'h8000_0000, 32'd31);       // R8 long rotate
        apply(1'b1, 4'd15, 32'd0, 32'd0);                // R12
        apply(1'b0, 4'd0, 32'd0, 32'd0);                 // R10 idle

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, t;
            r = ($urandom % 8 == 0) ? 32'd0 : $urandom;
            t = ($urandom % 8 == 0) ? r : $urandom;
            apply(($urandom % 4) != 0, 4'($urandom % 16), r, t);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule